// File: doc/BRIEF.md
# Operand Address Generator

This block turns an addressing-mode code and its raw operands into a 24-bit operand address. It serves a 16-bit processor core whose general registers are 32 bits wide. The decoder presents the mode, the instruction class, the operand size, the contents of the selected register, the displacement or absolute field, and the current program counter, then pulses `start`. One cycle later the block pulses `done` and shows the address. For the increment and decrement modes it also shows the updated register value. If the instruction class may not use the mode, it raises an illegal flag instead.

For memory-indirect operands the block reads a pointer from memory through a request/acknowledge handshake and returns that pointer as the address. While that read is outstanding the block reports itself busy and ignores new requests.

Top module: `eag_unit`

## Requirements
- R1: Synchronous active-high reset clears `done`, `ea_valid`, `wb_en`, `illegal`, `rd_req`, `busy` and `ea`. It also abandons a pending pointer read.
- R2: Register indirect (mode 1): `ea` equals bits 23:0 of `reg_val`. `done` is high in the cycle after the `start` edge, and all outputs are registered.
- R3: Displacement modes add the field to bits 23:0 of the register, modulo 2^24. In mode 2 the field's low 16 bits are sign-extended and the upper field bits are ignored. In mode 3 all 24 field bits are used unchanged.
- R4: Absolute modes: mode 6 fills bits 23:8 with ones above the field's low 8 bits, mode 7 sign-extends the field's low 16 bits, and mode 8 uses all 24 field bits.
- R5: Post-increment (mode 4): `ea` is the unmodified register's bits 23:0. `wb_val` is the register plus the step, with `wb_en` high. The step is 1 for size code 0, 2 for size code 1, and 4 for size codes 2 and 3. `wb_en` is never high without `ea_valid`.
- R6: Pre-decrement (mode 5): `wb_val` is the register minus the step, and `ea` is bits 23:0 of that result.
- R7: PC-relative: mode 10 sign-extends the field's low 8 bits and mode 11 sign-extends its low 16 bits. The result is added to `pc` modulo 2^24.
- R8: Register direct (mode 0) and immediate (mode 9) complete with `done` while `ea_valid` and `wb_en` stay low.
- R9: Class 0 (arithmetic/logic) allows only modes 0 and 9. Class 1 (data transfer) allows modes 0 to 9 but not 10, 11 or 12.
- R10: Class 2 (bit manipulation) allows only modes 0, 1 and 6. Class 3 (control transfer) allows only modes 10, 11 and 12. Codes 13 to 15 are illegal in every class. An illegal request sets `illegal`, pulses `done`, keeps `ea_valid`, `wb_en` and `rd_req` low, and issues no read.
- R11: Memory indirect (mode 12) raises `rd_req` one cycle after `start`. The request is at the field's low 8 bits zero-extended, and it holds until `rd_ack`. The cycle after the acknowledge, `done` pulses, `rd_req` drops, and `ea` is `rd_data` bits 23:0 with `ea_valid` high.
- R12: While `busy` is high, `start` is ignored. No extra `done` and no change of request address follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing-mode code |
| iclass | input | 2 | Instruction class code |
| opsize | input | 2 | Operand size code |
| reg_val | input | 32 | Contents of the selected register |
| fld | input | 24 | Displacement or absolute field |
| pc | input | 24 | Current program counter |
| ea | output | 24 | Effective address |
| ea_valid | output | 1 | `ea` holds an address |
| wb_en | output | 1 | `wb_val` must be written back to the register |
| wb_val | output | 32 | Updated register value |
| illegal | output | 1 | Mode not allowed for the class |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Pointer read outstanding |
| rd_req | output | 1 | Pointer read request |
| rd_addr | output | 24 | Pointer location |
| rd_ack | input | 1 | Pointer read acknowledge |
| rd_data | input | 32 | Pointer read data |

## Verification
The bench builds the block with its defaults: a 24-bit address, 32-bit registers, and short and medium fields of 8 and 16 bits. At these widths the register values near 2^24 and the program counter near the top of the space make a carry leave the address field. The bench can then show that the address wraps while the 32-bit write-back keeps the carry. The same widths put the sign bits of both short field forms in reach, and the all-ones fill of the 8-bit absolute form can be checked against the sign-extended 16-bit form on the same field value.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_RDIR  = 4'd0,
        AM_RIND  = 4'd1,
        AM_D16   = 4'd2,
        AM_D24   = 4'd3,
        AM_PINC  = 4'd4,
        AM_PDEC  = 4'd5,
        AM_ABS8  = 4'd6,
        AM_ABS16 = 4'd7,
        AM_ABS24 = 4'd8,
        AM_IMM   = 4'd9,
        AM_PC8   = 4'd10,
        AM_PC16  = 4'd11,
        AM_MIND  = 4'd12
    } am_e;

    typedef enum logic [1:0] {
        IC_ALU  = 2'd0,
        IC_XFER = 2'd1,
        IC_BIT  = 2'd2,
        IC_CTRL = 2'd3
    } ic_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fsm_e;

    // size code to byte step
    function automatic logic [2:0] step_of(input logic [1:0] sz);
        logic [2:0] s;
        case (sz)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

    // which modes each class may use
    function automatic logic mode_allowed(input logic [3:0] m, input logic [1:0] c);
        logic ok;
        case (ic_e'(c))
            IC_ALU:  ok = (m == AM_RDIR) || (m == AM_IMM);
            IC_XFER: ok = (m <= AM_IMM);
            IC_BIT:  ok = (m == AM_RDIR) || (m == AM_RIND) || (m == AM_ABS8);
            default: ok = (m == AM_PC8) || (m == AM_PC16) || (m == AM_MIND);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/eag_legal.sv
module eag_legal
    import eag_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [1:0] iclass,
    output logic       legal
);

    always_comb begin
        legal = mode_allowed(mode, iclass);
    end

endmodule

// File: rtl/eag_calc.sv
module eag_calc
    import eag_pkg::*;
#(
    parameter int EA_W    = 24,
    parameter int GPR_W   = 32,
    parameter int SHORT_W = 8,
    parameter int MID_W   = 16
) (
    input  logic [3:0]       mode,
    input  logic [1:0]       opsize,
    input  logic [GPR_W-1:0] reg_val,
    input  logic [EA_W-1:0]  fld,
    input  logic [EA_W-1:0]  pc,
    output logic [EA_W-1:0]  ea,
    output logic             has_ea,
    output logic             wb_en,
    output logic [GPR_W-1:0] wb_val,
    output logic             fetch,
    output logic [EA_W-1:0]  ptr_addr
);

    localparam int HI_S     = EA_W - SHORT_W;
    localparam int HI_M     = EA_W - MID_W;
    localparam int STEP_PAD = GPR_W - 3;

    logic [EA_W-1:0]  reg_lo;
    logic [EA_W-1:0]  short_sx;
    logic [EA_W-1:0]  mid_sx;
    logic [EA_W-1:0]  short_top;
    logic [EA_W-1:0]  short_zx;
    logic [GPR_W-1:0] step;
    logic [GPR_W-1:0] reg_inc;
    logic [GPR_W-1:0] reg_dec;

    always_comb begin
        reg_lo    = reg_val[EA_W-1:0];
        short_sx  = {{HI_S{fld[SHORT_W-1]}}, fld[SHORT_W-1:0]};
        mid_sx    = {{HI_M{fld[MID_W-1]}}, fld[MID_W-1:0]};
        short_top = {{HI_S{1'b1}}, fld[SHORT_W-1:0]};
        short_zx  = {{HI_S{1'b0}}, fld[SHORT_W-1:0]};
        step      = {{STEP_PAD{1'b0}}, step_of(opsize)};
        reg_inc   = reg_val + step;
        reg_dec   = reg_val - step;
    end

    always_comb begin
        ea       = '0;
        has_ea   = 1'b0;
        wb_en    = 1'b0;
        wb_val   = '0;
        fetch    = 1'b0;
        ptr_addr = '0;
        case (am_e'(mode))
            AM_RIND: begin
                ea     = reg_lo;
                has_ea = 1'b1;
            end
            AM_D16: begin
                ea     = reg_lo + mid_sx;
                has_ea = 1'b1;
            end
            AM_D24: begin
                ea     = reg_lo + fld;
                has_ea = 1'b1;
            end
            AM_PINC: begin
                ea     = reg_lo;
                has_ea = 1'b1;
                wb_en  = 1'b1;
                wb_val = reg_inc;
            end
            AM_PDEC: begin
                ea     = reg_dec[EA_W-1:0];
                has_ea = 1'b1;
                wb_en  = 1'b1;
                wb_val = reg_dec;
            end
            AM_ABS8: begin
                ea     = short_top;
                has_ea = 1'b1;
            end
            AM_ABS16: begin
                ea     = mid_sx;
                has_ea = 1'b1;
            end
            AM_ABS24: begin
                ea     = fld;
                has_ea = 1'b1;
            end
            AM_PC8: begin
                ea     = pc + short_sx;
                has_ea = 1'b1;
            end
            AM_PC16: begin
                ea     = pc + mid_sx;
                has_ea = 1'b1;
            end
            AM_MIND: begin
                fetch    = 1'b1;
                ptr_addr = short_zx;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
#(
    parameter int EA_W  = 24,
    parameter int GPR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             legal,
    input  logic [EA_W-1:0]  c_ea,
    input  logic             c_has_ea,
    input  logic             c_wb_en,
    input  logic [GPR_W-1:0] c_wb_val,
    input  logic             c_fetch,
    input  logic [EA_W-1:0]  c_ptr,
    input  logic             rd_ack,
    input  logic [GPR_W-1:0] rd_data,
    output logic [EA_W-1:0]  ea,
    output logic             ea_valid,
    output logic             wb_en,
    output logic [GPR_W-1:0] wb_val,
    output logic             illegal,
    output logic             done,
    output logic             busy,
    output logic             rd_req,
    output logic [EA_W-1:0]  rd_addr
);

    fsm_e state;
    logic unused_rd_hi;

    assign unused_rd_hi = ^rd_data[GPR_W-1:EA_W];
    assign busy = (state == ST_FETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ea       <= '0;
            ea_valid <= 1'b0;
            wb_en    <= 1'b0;
            wb_val   <= '0;
            illegal  <= 1'b0;
            done     <= 1'b0;
            rd_req   <= 1'b0;
            rd_addr  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        wb_val <= c_wb_val;
                        if (!legal) begin
                            illegal  <= 1'b1;
                            ea       <= '0;
                            ea_valid <= 1'b0;
                            wb_en    <= 1'b0;
                            done     <= 1'b1;
                        end else if (c_fetch) begin
                            illegal  <= 1'b0;
                            ea_valid <= 1'b0;
                            wb_en    <= 1'b0;
                            rd_req   <= 1'b1;
                            rd_addr  <= c_ptr;
                            state    <= ST_FETCH;
                        end else begin
                            illegal  <= 1'b0;
                            ea       <= c_ea;
                            ea_valid <= c_has_ea;
                            wb_en    <= c_wb_en;
                            done     <= 1'b1;
                        end
                    end
                end
                default: begin
                    if (rd_ack) begin
                        rd_req   <= 1'b0;
                        ea       <= rd_data[EA_W-1:0];
                        ea_valid <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R11
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_ack) |=> (done && ea_valid && !busy && !rd_req));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!ea_valid && !wb_en && !rd_req));

    // R5
    wb_needs_ea_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ea_valid);

    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_ack) |=> (busy && !done));

endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int EA_W    = 24,
    parameter int GPR_W   = 32,
    parameter int SHORT_W = 8,
    parameter int MID_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [1:0]       iclass,
    input  logic [1:0]       opsize,
    input  logic [GPR_W-1:0] reg_val,
    input  logic [EA_W-1:0]  fld,
    input  logic [EA_W-1:0]  pc,
    output logic [EA_W-1:0]  ea,
    output logic             ea_valid,
    output logic             wb_en,
    output logic [GPR_W-1:0] wb_val,
    output logic             illegal,
    output logic             done,
    output logic             busy,
    output logic             rd_req,
    output logic [EA_W-1:0]  rd_addr,
    input  logic             rd_ack,
    input  logic [GPR_W-1:0] rd_data
);

    logic             legal;
    logic [EA_W-1:0]  c_ea;
    logic             c_has_ea;
    logic             c_wb_en;
    logic [GPR_W-1:0] c_wb_val;
    logic             c_fetch;
    logic [EA_W-1:0]  c_ptr;

    eag_legal i_legal (
        .mode   (mode),
        .iclass (iclass),
        .legal  (legal)
    );

    eag_calc #(
        .EA_W    (EA_W),
        .GPR_W   (GPR_W),
        .SHORT_W (SHORT_W),
        .MID_W   (MID_W)
    ) i_calc (
        .mode     (mode),
        .opsize   (opsize),
        .reg_val  (reg_val),
        .fld      (fld),
        .pc       (pc),
        .ea       (c_ea),
        .has_ea   (c_has_ea),
        .wb_en    (c_wb_en),
        .wb_val   (c_wb_val),
        .fetch    (c_fetch),
        .ptr_addr (c_ptr)
    );

    eag_ctrl #(
        .EA_W  (EA_W),
        .GPR_W (GPR_W)
    ) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .legal    (legal),
        .c_ea     (c_ea),
        .c_has_ea (c_has_ea),
        .c_wb_en  (c_wb_en),
        .c_wb_val (c_wb_val),
        .c_fetch  (c_fetch),
        .c_ptr    (c_ptr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .ea       (ea),
        .ea_valid (ea_valid),
        .wb_en    (wb_en),
        .wb_val   (wb_val),
        .illegal  (illegal),
        .done     (done),
        .busy     (busy),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr)
    );

endmodule

// File: tb/test_eag_unit.sv
module test_eag_unit;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  mode;
        logic [1:0]  cls;
        logic [1:0]  size;
        logic [31:0] regv;
        logic [23:0] fld;
        logic [23:0] pc;
        logic [23:0] x_ea;
        logic        x_v;
        logic        x_wb_en;
        logic [31:0] x_wb;
        logic        x_ill;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        // R2 register indirect drops bits 31:24
        '{4'd2,  4'd1,  2'd1, 2'd0, 32'hDE12_3456, 24'h000000, 24'h000000, 24'h123456, 1'b1, 1'b0, 32'h0, 1'b0},
        // R3 16-bit displacement, positive
        '{4'd3,  4'd2,  2'd1, 2'd0, 32'h0000_1000, 24'h007FFF, 24'h000000, 24'h008FFF, 1'b1, 1'b0, 32'h0, 1'b0},
        // R3 16-bit displacement, negative, upper field bits ignored
        '{4'd3,  4'd2,  2'd1, 2'd0, 32'h0000_1000, 24'hABFFF0, 24'h000000, 24'h000FF0, 1'b1, 1'b0, 32'h0, 1'b0},
        // R3 24-bit displacement wraps
        '{4'd3,  4'd3,  2'd1, 2'd0, 32'h00FF_FFF0, 24'h000020, 24'h000000, 24'h000010, 1'b1, 1'b0, 32'h0, 1'b0},
        // R3 24-bit displacement used unchanged
        '{4'd3,  4'd3,  2'd1, 2'd0, 32'h0000_0010, 24'h800000, 24'h000000, 24'h800010, 1'b1, 1'b0, 32'h0, 1'b0},
        // R4 8-bit absolute fills with ones
        '{4'd4,  4'd6,  2'd1, 2'd0, 32'h0,         24'h123480, 24'h000000, 24'hFFFF80, 1'b1, 1'b0, 32'h0, 1'b0},
        // R4 16-bit absolute, sign bit set
        '{4'd4,  4'd7,  2'd1, 2'd0, 32'h0,         24'h009000, 24'h000000, 24'hFF9000, 1'b1, 1'b0, 32'h0, 1'b0},
        // R4 16-bit absolute, sign clear
        '{4'd4,  4'd7,  2'd1, 2'd0, 32'h0,         24'hFF1234, 24'h000000, 24'h001234, 1'b1, 1'b0, 32'h0, 1'b0},
        // R4 24-bit absolute
        '{4'd4,  4'd8,  2'd1, 2'd0, 32'h0,         24'hABCDEF, 24'h000000, 24'hABCDEF, 1'b1, 1'b0, 32'h0, 1'b0},
        // R5 post-increment byte
        '{4'd5,  4'd4,  2'd1, 2'd0, 32'h0000_2000, 24'h0,      24'h000000, 24'h002000, 1'b1, 1'b1, 32'h0000_2001, 1'b0},
        // R5 post-increment long, carry past bit 23
        '{4'd5,  4'd4,  2'd1, 2'd2, 32'h00FF_FFFE, 24'h0,      24'h000000, 24'hFFFFFE, 1'b1, 1'b1, 32'h0100_0002, 1'b0},
        // R5 size code 3 also steps by four
        '{4'd5,  4'd4,  2'd1, 2'd3, 32'h0000_0100, 24'h0,      24'h000000, 24'h000100, 1'b1, 1'b1, 32'h0000_0104, 1'b0},
        // R6 pre-decrement word
        '{4'd6,  4'd5,  2'd1, 2'd1, 32'h0000_3000, 24'h0,      24'h000000, 24'h002FFE, 1'b1, 1'b1, 32'h0000_2FFE, 1'b0},
        // R6 pre-decrement long from zero
        '{4'd6,  4'd5,  2'd1, 2'd2, 32'h0000_0000, 24'h0,      24'h000000, 24'hFFFFFC, 1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0},
        // R7 8-bit PC-relative, negative
        '{4'd7,  4'd10, 2'd3, 2'd0, 32'h0,         24'h0000FE, 24'h000100, 24'h0000FE, 1'b1, 1'b0, 32'h0, 1'b0},
        // R7 16-bit PC-relative wraps
        '{4'd7,  4'd11, 2'd3, 2'd0, 32'h0,         24'h000020, 24'hFFFFF0, 24'h000010, 1'b1, 1'b0, 32'h0, 1'b0},
        // R7 16-bit PC-relative, negative
        '{4'd7,  4'd11, 2'd3, 2'd0, 32'h0,         24'h008000, 24'h001000, 24'hFF9000, 1'b1, 1'b0, 32'h0, 1'b0},
        // R8 register direct gives no address
        '{4'd8,  4'd0,  2'd0, 2'd0, 32'h1234_5678, 24'h0,      24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b0},
        // R8 immediate gives no address
        '{4'd8,  4'd9,  2'd0, 2'd0, 32'h0,         24'hFFFFFF, 24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b0},
        // R9 arithmetic class with register indirect
        '{4'd9,  4'd1,  2'd0, 2'd0, 32'h0000_4000, 24'h0,      24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R9 transfer class with PC-relative
        '{4'd9,  4'd10, 2'd1, 2'd0, 32'h0,         24'h000004, 24'h000100, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R9 transfer class with memory indirect
        '{4'd9,  4'd12, 2'd1, 2'd0, 32'h0,         24'h000010, 24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R9 transfer class with immediate is legal
        '{4'd9,  4'd9,  2'd1, 2'd0, 32'h0,         24'h000001, 24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b0},
        // R10 bit class with 8-bit absolute
        '{4'd10, 4'd6,  2'd2, 2'd0, 32'h0,         24'h000005, 24'h000000, 24'hFFFF05, 1'b1, 1'b0, 32'h0, 1'b0},
        // R10 bit class with 16-bit absolute
        '{4'd10, 4'd7,  2'd2, 2'd0, 32'h0,         24'h000005, 24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R10 undefined code 13
        '{4'd10, 4'd13, 2'd1, 2'd0, 32'h0,         24'h0,      24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R10 arithmetic class post-increment: no write-back
        '{4'd10, 4'd4,  2'd0, 2'd2, 32'h0000_0040, 24'h0,      24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1},
        // R10 control class with register direct
        '{4'd10, 4'd0,  2'd3, 2'd0, 32'h0,         24'h0,      24'h000000, 24'h0,      1'b0, 1'b0, 32'h0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  iclass = '0;
    logic [1:0]  opsize = '0;
    logic [31:0] reg_val = '0;
    logic [23:0] fld = '0;
    logic [23:0] pc = '0;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic [23:0] ea;
    logic        ea_valid;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        illegal;
    logic        done;
    logic        busy;
    logic        rd_req;
    logic [23:0] rd_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    eag_unit i_eag_unit (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (mode),
        .iclass   (iclass),
        .opsize   (opsize),
        .reg_val  (reg_val),
        .fld      (fld),
        .pc       (pc),
        .ea       (ea),
        .ea_valid (ea_valid),
        .wb_en    (wb_en),
        .wb_val   (wb_val),
        .illegal  (illegal),
        .done     (done),
        .busy     (busy),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual %0d cycles expected fewer", 200000);
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "ea_valid", {31'd0, ea_valid}, 32'd0);
        chk("R1", "wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1", "illegal", {31'd0, illegal}, 32'd0);
        chk("R1", "rd_req", {31'd0, rd_req}, 32'd0);
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "ea", {8'd0, ea}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            @(negedge clk);
            mode    = VECS[i].mode;
            iclass  = VECS[i].cls;
            opsize  = VECS[i].size;
            reg_val = VECS[i].regv;
            fld     = VECS[i].fld;
            pc      = VECS[i].pc;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(tag, $sformatf("vec%0d done", i), {31'd0, done}, 32'd1);
            chk(tag, $sformatf("vec%0d illegal", i), {31'd0, illegal}, {31'd0, VECS[i].x_ill});
            chk(tag, $sformatf("vec%0d ea_valid", i), {31'd0, ea_valid}, {31'd0, VECS[i].x_v});
            chk(tag, $sformatf("vec%0d wb_en", i), {31'd0, wb_en}, {31'd0, VECS[i].x_wb_en});
            chk(tag, $sformatf("vec%0d rd_req", i), {31'd0, rd_req}, 32'd0);
            if (VECS[i].x_v)
                chk(tag, $sformatf("vec%0d ea", i), {8'd0, ea}, {8'd0, VECS[i].x_ea});
            if (VECS[i].x_wb_en)
                chk(tag, $sformatf("vec%0d wb_val", i), wb_val, VECS[i].x_wb);
        end

        // R2 done is a single-cycle strobe
        @(negedge clk);
        chk("R2", "done drops", {31'd0, done}, 32'd0);

        // R11 memory indirect with a delayed acknowledge
        @(negedge clk);
        mode   = 4'd12;
        iclass = 2'd3;
        fld    = 24'h770042;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "rd_req raised", {31'd0, rd_req}, 32'd1);
        chk("R11", "rd_addr", {8'd0, rd_addr}, 32'h0000_0042);
        chk("R11", "busy", {31'd0, busy}, 32'd1);
        chk("R11", "no done yet", {31'd0, done}, 32'd0);
        // R12 a start while busy is ignored
        mode    = 4'd1;
        iclass  = 2'd1;
        reg_val = 32'h0055_5555;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12", "no done while busy", {31'd0, done}, 32'd0);
        chk("R12", "rd_addr kept", {8'd0, rd_addr}, 32'h0000_0042);
        repeat (2) @(negedge clk);
        chk("R11", "rd_req held", {31'd0, rd_req}, 32'd1);
        rd_ack  = 1'b1;
        rd_data = 32'hAB12_3456;
        @(negedge clk);
        rd_ack = 1'b0;
        chk("R11", "done after ack", {31'd0, done}, 32'd1);
        chk("R11", "pointer ea", {8'd0, ea}, 32'h0012_3456);
        chk("R11", "ea_valid", {31'd0, ea_valid}, 32'd1);
        chk("R11", "rd_req dropped", {31'd0, rd_req}, 32'd0);
        chk("R11", "busy cleared", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R12", "no queued result", {31'd0, done}, 32'd0);

        // R1 reset abandons a pending read
        mode   = 4'd12;
        iclass = 2'd3;
        fld    = 24'h000080;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "second read", {31'd0, rd_req}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "rd_req cleared", {31'd0, rd_req}, 32'd0);
        chk("R1", "busy cleared", {31'd0, busy}, 32'd0);
        chk("R1", "ea_valid cleared", {31'd0, ea_valid}, 32'd0);

        finish_run();
    end

endmodule